// File: doc/BRIEF.md
# Configurable Fabric Register Tile

This block is the single-bit storage tile of a programmable logic fabric. It holds one bit that is loaded on an active clock edge from one of two data sources: a short direct path from the neighbouring combinational tile, or a general routed input. A load enable gates every update. The clock is taken from one of eight chip-wide clock lines or from a user-driven line, and a static polarity bit decides whether the rising or the falling edge is active.

Two local asynchronous controls, both active low, force the bit to 0 or to 1 at any time. If both are asserted together, the bit is 0. A chip-wide initialisation phase also forces every tile. A static configuration bit decides whether that phase leaves the tile cleared or preset. Outside that phase the global controls are inactive. Clear takes priority over preset whether each comes from the local pins or from the chip-wide phase.

All configuration inputs (clock select, polarity, initial value) are treated as static while the fabric is running.

Top module: `fabric_reg_tile`

## Requirements
- R1: On an active clock edge with `dataEn`=1, `y` takes `dirIn` when `srcSel`=0 and `routeIn` when `srcSel`=1.
- R2: On an active clock edge with `dataEn`=0, `y` keeps its value.
- R3: While `clrN`=0, `y` is 0 at once, without any clock edge. After `clrN` is released with no edge, `y` stays 0.
- R4: While `presetN`=0, `clrN`=1 and `chipInit`=0, `y` is 1 at once, without any clock edge.
- R5: While `clrN`=0 and `presetN`=0 together, `y` is 0.
- R6: While `chipInit`=1 and both local controls are 1, `y` equals `initHigh`. Here 0 means the global clear is active and 1 means the global preset is active.
- R7: Clear priority also holds across sources. `clrN`=0 gives 0 during `chipInit` with `initHigh`=1. `chipInit` with `initHigh`=0 gives 0 while `presetN`=0.
- R8: Clock selection uses `clkSel`. Values 0 to 3 pick `fastClk[clkSel]`. Values 4 to 7 pick `routedClk[clkSel-4]`. Value 8 picks `userClk`. Edges on lines that are not selected have no effect.
- R9: For `clkSel` values 9 to 15 the tile clock is held low. No edge on any line loads `y`.
- R10: With `clkInv`=0 only the rising edge of the selected line loads. With `clkInv`=1 only the falling edge loads.
- R11: Once all asynchronous controls are released, the first active edge with `dataEn`=1 loads the selected data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fastClk | input | NUM_FAST (4) | Fast hardwired clock lines, select codes 0 to 3 |
| routedClk | input | NUM_ROUTED (4) | Routed clock lines, select codes 4 to 7 |
| userClk | input | 1 | User clock line, select code 8 |
| clkSel | input | SEL_W (4) | Static clock-source select |
| clkInv | input | 1 | Static polarity: 0 rising edge, 1 falling edge |
| dirIn | input | 1 | Direct-connect data from the adjacent combinational tile |
| routeIn | input | 1 | Routed data input |
| srcSel | input | 1 | Data source select: 0 dirIn, 1 routeIn |
| dataEn | input | 1 | Load enable, active high |
| clrN | input | 1 | Local asynchronous clear, active low |
| presetN | input | 1 | Local asynchronous preset, active low |
| chipInit | input | 1 | Chip-wide initialisation phase, active high |
| initHigh | input | 1 | Static initial value: 0 global clear, 1 global preset |
| y | output | 1 | Stored bit |

## Verification
The hardest situation to reach is an edge on the wrong line, or the wrong edge on the right line, that still loads. From the output alone this looks the same as a correct hold unless the stored bit is known to differ from the incoming data. Before every single-line pulse, the stimulus therefore forces the bit asynchronously to the complement of the selected data. It then raises and lowers exactly one clock line and checks the output after each transition. This is swept over all 15 manually driven select codes, both polarities, both data sources, the enable and all eight pulsable lines. The free-running line at code 0 is exercised last, so that the select change cannot make a stray edge.

// File: rtl/fabtile_pkg.sv
package fabtile_pkg;
  // Strobes handed from the control half to the storage half.
  typedef struct packed {
    logic cellClk;    // selected clock line, before polarity
    logic forceLo;    // merged clear (local or chip-wide)
    logic forceHi;    // merged preset, already masked by clear
    logic loadEn;     // load enable
    logic pickRouted; // data source select
    logic negEdge;    // falling edge is active
  } tileCtl_t;
endpackage

// File: rtl/tile_ctrl.sv
module tile_ctrl
  import fabtile_pkg::*;
#(
  parameter int NUM_FAST   = 4,
  parameter int NUM_ROUTED = 4,
  parameter int SEL_W      = 4
) (
  input  logic [NUM_FAST-1:0]   fastClk,
  input  logic [NUM_ROUTED-1:0] routedClk,
  input  logic                  userClk,
  input  logic [SEL_W-1:0]      clkSel,
  input  logic                  clkInv,
  input  logic                  srcSel,
  input  logic                  dataEn,
  input  logic                  clrN,
  input  logic                  presetN,
  input  logic                  chipInit,
  input  logic                  initHigh,
  output tileCtl_t              ctl
);
  localparam int NUM_LINES = NUM_FAST + NUM_ROUTED + 1;

  logic [NUM_LINES-1:0] lineVec;
  logic [NUM_LINES-1:0] lineHit;
  logic globClr;
  logic globSet;

  assign lineVec = {userClk, routedClk, fastClk};

  // One decoder per line; unmatched codes leave every hit low.
  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    assign lineHit[g] = (clkSel == SEL_W'(g)) & lineVec[g];
  end

  assign globClr = chipInit & ~initHigh;
  assign globSet = chipInit & initHigh;

  always_comb begin
    ctl.cellClk    = |lineHit;
    ctl.forceLo    = ~clrN | globClr;
    ctl.forceHi    = ~ctl.forceLo & (~presetN | globSet);
    ctl.loadEn     = dataEn;
    ctl.pickRouted = srcSel;
    ctl.negEdge    = clkInv;
  end
endmodule

// File: rtl/tile_dp.sv
module tile_dp
  import fabtile_pkg::*;
(
  input  tileCtl_t ctl,
  input  logic     dirIn,
  input  logic     routeIn,
  output logic     y
);
  logic clkW;
  logic loW;
  logic hiW;
  logic dNext;
  logic qRise;
  logic qFall;

  assign clkW  = ctl.cellClk;
  assign loW   = ctl.forceLo;
  assign hiW   = ctl.forceHi;
  assign dNext = ctl.pickRouted ? routeIn : dirIn;

  always_ff @(posedge clkW or posedge loW or posedge hiW) begin
    if (loW)             qRise <= 1'b0;
    else if (hiW)        qRise <= 1'b1;
    else if (ctl.loadEn) qRise <= dNext;
  end

  always_ff @(negedge clkW or posedge loW or posedge hiW) begin
    if (loW)             qFall <= 1'b0;
    else if (hiW)        qFall <= 1'b1;
    else if (ctl.loadEn) qFall <= dNext;
  end

  // Polarity is static, so the unused register is simply never observed.
  assign y = ctl.negEdge ? qFall : qRise;
endmodule

// File: rtl/fabric_reg_tile.sv
module fabric_reg_tile
  import fabtile_pkg::*;
#(
  parameter int NUM_FAST   = 4,
  parameter int NUM_ROUTED = 4,
  localparam int SEL_W     = $clog2(NUM_FAST + NUM_ROUTED + 1)
) (
  input  logic [NUM_FAST-1:0]   fastClk,
  input  logic [NUM_ROUTED-1:0] routedClk,
  input  logic                  userClk,
  input  logic [SEL_W-1:0]      clkSel,
  input  logic                  clkInv,
  input  logic                  dirIn,
  input  logic                  routeIn,
  input  logic                  srcSel,
  input  logic                  dataEn,
  input  logic                  clrN,
  input  logic                  presetN,
  input  logic                  chipInit,
  input  logic                  initHigh,
  output logic                  y
);
  tileCtl_t ctl;

  tile_ctrl #(
    .NUM_FAST  (NUM_FAST),
    .NUM_ROUTED(NUM_ROUTED),
    .SEL_W     (SEL_W)
  ) u_ctrl (
    .fastClk  (fastClk),
    .routedClk(routedClk),
    .userClk  (userClk),
    .clkSel   (clkSel),
    .clkInv   (clkInv),
    .srcSel   (srcSel),
    .dataEn   (dataEn),
    .clrN     (clrN),
    .presetN  (presetN),
    .chipInit (chipInit),
    .initHigh (initHigh),
    .ctl      (ctl)
  );

  tile_dp u_dp (
    .ctl    (ctl),
    .dirIn  (dirIn),
    .routeIn(routeIn),
    .y      (y)
  );
endmodule

// File: rtl/tile_chk.sv
module tile_chk #(
  parameter int NUM_FAST   = 4,
  parameter int NUM_ROUTED = 4,
  parameter int SEL_W      = 4
) (
  input logic [NUM_FAST-1:0]   fastClk,
  input logic [NUM_ROUTED-1:0] routedClk,
  input logic                  userClk,
  input logic [SEL_W-1:0]      clkSel,
  input logic                  clkInv,
  input logic                  dirIn,
  input logic                  routeIn,
  input logic                  srcSel,
  input logic                  dataEn,
  input logic                  clrN,
  input logic                  presetN,
  input logic                  chipInit,
  input logic                  initHigh,
  input logic                  y
);
  logic asyncAny;
  assign asyncAny = chipInit | ~clrN | ~presetN;

  AST_CLR_WINS: assert property (@(posedge fastClk[0]) disable iff (chipInit)
    !clrN |-> (y == 1'b0)); // R3

  AST_PRESET_SETS: assert property (@(posedge fastClk[0]) disable iff (chipInit)
    (clrN && !presetN) |-> (y == 1'b1)); // R4

  AST_INIT_VALUE: assert property (@(posedge fastClk[0]) disable iff (!clrN || !presetN)
    chipInit |-> (y == initHigh)); // R6

  AST_EN_HOLD: assert property (@(posedge fastClk[0]) disable iff (asyncAny)
    (clkSel == '0 && !clkInv && !dataEn) |=> $stable(y)); // R2

  AST_SRC_LOAD: assert property (@(posedge fastClk[0]) disable iff (asyncAny)
    (clkSel == '0 && !clkInv && dataEn) |=> (y == $past(srcSel ? routeIn : dirIn))); // R1
endmodule

bind fabric_reg_tile tile_chk #(
  .NUM_FAST  (NUM_FAST),
  .NUM_ROUTED(NUM_ROUTED),
  .SEL_W     (SEL_W)
) u_chk (.*);

// File: tb/sim_fabric_reg_tile.sv
`timescale 1ns/1ps
module sim_fabric_reg_tile;
  logic       clk = 1'b0;
  logic [3:1] fastHi;
  logic [3:0] routedClk;
  logic       userClk;
  logic [3:0] clkSel;
  logic       clkInv, dirIn, routeIn, srcSel, dataEn;
  logic       clrN, presetN, chipInit, initHigh;
  logic       y;
  int         total = 0;
  int         bad = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk; // 200 MHz on fast line 0

  fabric_reg_tile u0 (
    .fastClk  ({fastHi, clk}),
    .routedClk(routedClk),
    .userClk  (userClk),
    .clkSel   (clkSel),
    .clkInv   (clkInv),
    .dirIn    (dirIn),
    .routeIn  (routeIn),
    .srcSel   (srcSel),
    .dataEn   (dataEn),
    .clrN     (clrN),
    .presetN  (presetN),
    .chipInit (chipInit),
    .initHigh (initHigh),
    .y        (y)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  // Lines 1..8 map to select codes 1..8; line 0 is the free clock.
  task automatic driveLine(input int t, input logic v);
    if (t <= 3)      fastHi[t] = v;
    else if (t <= 7) routedClk[t-4] = v;
    else             userClk = v;
  endtask

  initial begin
    #200000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    fastHi = '0; routedClk = '0; userClk = 1'b0;
    clkSel = 4'd15; clkInv = 1'b0; dirIn = 1'b0; routeIn = 1'b0;
    srcSel = 1'b0; dataEn = 1'b0; clrN = 1'b1; presetN = 1'b1;
    chipInit = 1'b1; initHigh = 1'b0;
    #3;
    chk("R6 init clear", y, 1'b0);
    initHigh = 1'b1; #1;
    chk("R6 init preset", y, 1'b1);
    clrN = 1'b0; #1;
    chk("R7 local clear beats global preset", y, 1'b0);
    clrN = 1'b1; initHigh = 1'b0; presetN = 1'b0; #1;
    chk("R7 global clear beats local preset", y, 1'b0);
    presetN = 1'b1; chipInit = 1'b0; #1;
    chk("R3 hold after init", y, 1'b0);
    presetN = 1'b0; #1;
    chk("R4 local preset", y, 1'b1);
    clrN = 1'b0; #1;
    chk("R5 both low", y, 1'b0);
    presetN = 1'b1; #1;
    chk("R3 clear only", y, 1'b0);
    clrN = 1'b1; #1;
    chk("R3 release no edge", y, 1'b0);

    // Single-line pulse sweep over codes 1..15
    for (int sel = 1; sel < 16; sel++)
      for (int inv = 0; inv < 2; inv++)
        for (int src = 0; src < 2; src++)
          for (int en = 0; en < 2; en++)
            for (int d = 0; d < 2; d++)
              for (int t = 1; t <= 8; t++) begin
                logic dat, v0, hit, expRise, expFall;
                string tag;
                clkSel = 4'(sel); clkInv = 1'(inv); srcSel = 1'(src);
                dataEn = 1'(en); dirIn = 1'(d); routeIn = ~1'(d);
                dat = src[0] ? ~1'(d) : 1'(d);
                v0 = ~dat;
                #1;
                if (v0) presetN = 1'b0; else clrN = 1'b0;
                #1;
                presetN = 1'b1; clrN = 1'b1;
                #1;
                hit = (t == sel);
                expRise = (hit && inv == 0 && en == 1) ? dat : v0;
                expFall = (hit && en == 1) ? dat : v0;
                tag = (sel > 8) ? "R9 unused code" :
                      (en == 0) ? "R2 enable low" : "R8 R10 R11 R1 line edge";
                driveLine(t, 1'b1); #1;
                chk({tag, " rise"}, y, expRise);
                driveLine(t, 1'b0); #1;
                chk({tag, " fall"}, y, expFall);
              end

    // Free-running line at code 0
    clkSel = 4'd15; clkInv = 1'b0;
    @(negedge clk);
    clkSel = 4'd0; dataEn = 1'b1; srcSel = 1'b0; dirIn = 1'b1; routeIn = 1'b0;
    #0.5 clrN = 1'b0;
    #1   clrN = 1'b1;
    @(negedge clk); #0.5;
    chk("R11 R8 code0 first edge loads dirIn", y, 1'b1);
    dataEn = 1'b0; dirIn = 1'b0;
    @(negedge clk); #0.5;
    chk("R2 code0 hold", y, 1'b1);
    dataEn = 1'b1; srcSel = 1'b1;
    @(negedge clk); #0.5;
    chk("R1 code0 routed", y, 1'b0);
    routeIn = 1'b1;
    @(negedge clk); #0.5;
    chk("R1 code0 routed one", y, 1'b1);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule